// File: doc/BRIEF.md
# Back-EMF Zero-Crossing Majority Filter

This block cleans up the single-bit output of a back-EMF comparator before it is used to time motor commutation. The comparator bit is sampled on each strobe and pushed into a six-sample window. The newest sample enters at the least significant bit, and the oldest sample leaves from the most significant bit. The window is not checked with a plain majority compare. Instead it walks a 64-entry next-state table that is built inside the block. A non-event entry holds twice its own address, truncated to six bits. An event entry holds the marker value 1. On every strobe the next window value is the table entry at the current window plus the sample bit.

A zero-crossing candidate is any pattern whose three oldest samples hold at least two ones and whose three newest samples hold at least two zeros. Some candidates would fire one crossing twice, or would hide the ideal pattern `111000`, so they are dropped from the event set. When the window reaches an event pattern, the block gives a one-clock pulse and parks at window value 1. Further samples are ignored until the commutation logic clears the window back to 0.

Top module: `zcf_majority_filter`

## Requirements
- R1: After reset (`rst_ni` low), `window_o` reads 0 and `event_o` reads 0.
- R2: On a strobe, with no clear and not parked, where the result is not an event, `window_o` becomes `{old[4:0], sample_i}` one clock later. The oldest bit (bit 5) is discarded.
- R3: With `strobe_i` and `clear_i` both low, `window_o` holds its value and `event_o` stays 0.
- R4: The event set is exactly {24, 26, 42, 44, 52, 56, 57, 58}, with bit 5 the oldest sample. When a strobe moves the window onto one of these values, `event_o` is 1 for exactly the one clock that follows that strobe edge.
- R5: The candidate patterns 25, 28, 40, 41, 48, 49, 50 and 60 never raise `event_o`. The window simply shifts through them.
- R6: After an event, `window_o` reads 1. Strobes are then ignored: the window stays at 1 and no further event fires until a clear.
- R7: `clear_i` sets `window_o` to 0, ends the parked state and suppresses any event. A clear wins over a strobe in the same cycle.
- R8: Starting from a cleared window, the noiseless sequence 1,1,1,0,0,0 gives exactly one event, on the sixth sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Comparator sample bit |
| strobe_i | input | 1 | Takes `sample_i` into the window this cycle |
| clear_i | input | 1 | Clears the window and leaves the parked state |
| event_o | output | 1 | One-clock zero-crossing pulse |
| window_o | output | 6 | Current window / table address |

## Verification
The bench feeds every 6-bit pattern into a freshly cleared window, one bit per strobe, oldest bit first. This catches a table that keeps a pruned entry such as 60 or 28: such a table would fire one sample early and mask the ideal 56. It also catches a table that drops a kept entry: that table would miss the crossing altogether. Dedicated sequences cover the following cases:
- Strobes sent while parked. A design that does not park would fire again on every trailing zero.
- A clear in the same cycle as a strobe. A design with the wrong priority would shift instead of clearing.
- Idle cycles with no strobe. A design that shifts on every clock would drift.

// File: rtl/zcf_pkg.sv
package zcf_pkg;
  localparam int unsigned WIN_W    = 6;
  localparam int unsigned DEPTH    = 1 << WIN_W;
  localparam int unsigned HALF_W   = WIN_W / 2;
  localparam int unsigned MAJ      = HALF_W / 2 + 1;
  localparam int unsigned EVT_MARK = 1;

  // at least MAJ ones in the old half, at least MAJ zeros in the new half
  function automatic logic is_candidate(int unsigned pat);
    int unsigned ones_old;
    int unsigned zeros_new;
    ones_old  = 0;
    zeros_new = 0;
    for (int unsigned k = 0; k < HALF_W; k++) begin
      if (((pat >> (k + HALF_W)) & 1) == 1) ones_old++;
      if (((pat >> k) & 1) == 0) zeros_new++;
    end
    return (ones_old >= MAJ) && (zeros_new >= MAJ);
  endfunction

  // candidates that would shadow or repeat a neighbouring event
  function automatic logic is_pruned(int unsigned pat);
    case (pat)
      25, 28, 40, 41, 48, 49, 50, 60: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic is_event(int unsigned pat);
    return is_candidate(pat) && !is_pruned(pat);
  endfunction
endpackage

// File: rtl/zcf_table.sv
module zcf_table
  import zcf_pkg::*;
#(
  parameter int unsigned W = WIN_W,
  localparam int unsigned N = 1 << W
) (
  input  logic [W-1:0] rd_addr_i,
  output logic [W-1:0] rd_data_o,
  input  logic [W-1:0] probe_i,
  output logic         probe_evt_o
);
  logic [W-1:0] entry [N];
  logic [N-1:0] evt_map;

  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam logic [W-1:0] DBL = W'((i * 2) % N);
    localparam logic         EVT = is_event(i);
    assign entry[i]   = EVT ? W'(EVT_MARK) : DBL;
    assign evt_map[i] = EVT;
  end

  assign rd_data_o   = entry[rd_addr_i];
  assign probe_evt_o = evt_map[probe_i];
endmodule

// File: rtl/zcf_window.sv
module zcf_window
  import zcf_pkg::*;
#(
  parameter int unsigned W = WIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         strobe_i,
  input  logic         clear_i,
  input  logic [W-1:0] tbl_data_i,
  input  logic         probe_evt_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] probe_o,
  output logic         event_o
);
  logic [W-1:0] addr_q;
  logic         parked_q;
  logic         event_q;
  logic         take;

  assign probe_o = tbl_data_i + W'(sample_i);
  assign take    = strobe_i && !parked_q && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      parked_q <= 1'b0;
      event_q  <= 1'b0;
    end else if (clear_i) begin
      addr_q   <= '0;
      parked_q <= 1'b0;
      event_q  <= 1'b0;
    end else if (take) begin
      if (probe_evt_i) begin
        addr_q   <= W'(EVT_MARK);
        parked_q <= 1'b1;
        event_q  <= 1'b1;
      end else begin
        addr_q  <= probe_o;
        event_q <= 1'b0;
      end
    end else begin
      event_q <= 1'b0;
    end
  end

  assign addr_o  = addr_q;
  assign event_o = event_q;

  // R4
  evt_one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |=> !event_q);
  // R4
  evt_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(event_q) |-> $past(strobe_i) && !$past(clear_i));
  // R6
  parked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parked_q && !clear_i) |=> $stable(addr_q) && !event_q);
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (addr_q == '0) && !event_q);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !clear_i) |=> $stable(addr_q) && !event_q);
  // R2
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !probe_evt_i) |=> addr_q == {$past(addr_q[W-2:0]), $past(sample_i)});
endmodule

// File: rtl/zcf_majority_filter.sv
module zcf_majority_filter
  import zcf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             strobe_i,
  input  logic             clear_i,
  output logic             event_o,
  output logic [WIN_W-1:0] window_o
);
  logic [WIN_W-1:0] addr;
  logic [WIN_W-1:0] tbl_data;
  logic [WIN_W-1:0] probe;
  logic             probe_evt;

  zcf_table #(.W(WIN_W)) u_table (
    .rd_addr_i  (addr),
    .rd_data_o  (tbl_data),
    .probe_i    (probe),
    .probe_evt_o(probe_evt)
  );

  zcf_window #(.W(WIN_W)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .strobe_i   (strobe_i),
    .clear_i    (clear_i),
    .tbl_data_i (tbl_data),
    .probe_evt_i(probe_evt),
    .addr_o     (addr),
    .probe_o    (probe),
    .event_o    (event_o)
  );

  assign window_o = addr;
endmodule

// File: tb/sim_zcf_majority_filter.sv
`timescale 1ns/1ps
module sim_zcf_majority_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_i = 1'b0;
  logic       strobe_i = 1'b0;
  logic       clear_i = 1'b0;
  logic       event_o;
  logic [5:0] window_o;

  always #2.5 clk_i = ~clk_i;

  zcf_majority_filter u0 (
    .clk_i, .rst_ni, .sample_i, .strobe_i, .clear_i, .event_o, .window_o
  );

  typedef struct {
    logic [5:0] win;
    logic       ev;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  // bench model state
  logic [5:0] m_win = '0;
  logic       m_park = 1'b0;

  function automatic bit in_event_set(logic [5:0] p);  // R4
    return p inside {6'd24, 6'd26, 6'd42, 6'd44, 6'd52, 6'd56, 6'd57, 6'd58};
  endfunction
  function automatic bit in_pruned_set(logic [5:0] p); // R5
    return p inside {6'd25, 6'd28, 6'd40, 6'd41, 6'd48, 6'd49, 6'd50, 6'd60};
  endfunction

  task automatic step(input logic b, input logic s, input logic c, input string tag);
    exp_t e;
    logic [5:0] n;
    @(negedge clk_i);
    sample_i = b; strobe_i = s; clear_i = c;
    e.ev = 1'b0;
    if (c) begin
      m_win = '0; m_park = 1'b0; e.tag = "R7";
    end else if (s && !m_park) begin
      n = {m_win[4:0], b};
      if (in_event_set(n)) begin
        m_win = 6'd1; m_park = 1'b1; e.ev = 1'b1; e.tag = "R4";
      end else begin
        m_win = n; e.tag = in_pruned_set(n) ? "R5" : "R2";
      end
    end else if (s) begin
      e.tag = "R6";
    end else begin
      e.tag = "R3";
    end
    if (tag != "") e.tag = tag;
    e.win = m_win;
    q.push_back(e);
  endtask

  task automatic feed(input logic [5:0] p, input string tag);
    for (int k = 5; k >= 0; k--) step(p[k], 1'b1, 1'b0, tag);
  endtask

  // monitor
  always @(posedge clk_i) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_run++;
      if (window_o !== e.win || event_o !== e.ev) begin
        n_fail++;
        $display("FAIL %s: window=%0d event=%0b expected window=%0d event=%0b",
                 e.tag, window_o, event_o, e.win, e.ev);
      end
    end
  end

  initial begin
    #20;
    n_run++;
    if (window_o !== 6'd0 || event_o !== 1'b0) begin // R1
      n_fail++;
      $display("FAIL R1: window=%0d event=%0b expected window=0 event=0", window_o, event_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // R8 ideal crossing, then trailing samples ignored (R6)
    step(0, 0, 1, "R7");
    feed(6'b111000, "R8");
    for (int k = 0; k < 4; k++) step(k[0], 1'b1, 1'b0, "R6");
    step(0, 0, 0, "R6");
    // R5: 60 passed through, fires at 56
    step(0, 0, 1, "R7");
    feed(6'b001111, "R2");
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R5");
    step(0, 1, 0, "R4");
    // R3 idle cycles with sample toggling
    step(0, 0, 1, "R7");
    step(1, 1, 0, "R2");
    step(1, 0, 0, "R3");
    step(0, 0, 0, "R3");
    step(1, 1, 0, "R2");
    // R7 clear beats strobe
    step(1, 1, 1, "R7");
    step(1, 1, 0, "R2");
    // R5 pruned 28 reached, then 56 fires
    step(0, 0, 1, "R7");
    feed(6'b011100, "");
    step(0, 1, 0, "R4");
    // full sweep of every pattern
    for (int p = 0; p < 64; p++) begin
      step(0, 0, 1, "R7");
      feed(6'(p), "");
      step(1, 1, 0, "");
    end
    step(0, 0, 0, "");
    wait (q.size() == 0);
    @(posedge clk_i); #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule